// File: doc/BRIEF.md
# SPI Master Controller with Register Access

This block is a serial peripheral master that sits behind a small register port. Software selects the bit order, clock polarity, clock phase and serial clock rate in a control register. It then writes a byte to the data register. That write is the only way to start an exchange. The controller lowers the slave select, produces sixteen serial clock edges, sends the byte on `mosi` and assembles the byte arriving on `miso`. It then releases the select and raises a completion flag.

Software learns that a byte is finished by polling the status register or through the `irq` output. It clears the flag with a two-step sequence: a status read while a flag is up, then any access to the data register. A data write made while an exchange is still running does not reach the shifter. It only raises a collision flag.

Register map (`reg_addr`): 0 = control, 1 = status, 2 = data. Control bits: 7 interrupt enable, 6 block enable, 5 LSB-first, 4 master select, 3 CPOL, 2 CPHA, 1:0 rate select. Status bits: 7 completion, 6 collision, 0 double rate (the only writable status bit). Reads are combinational on `reg_rdata`.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset the control register, the status register and `irq` read 0, `ss_n` is 1 and `sck` is 0.
- R2: A data-register write starts an exchange only when control bit 6 (enable) and bit 4 (master) are both 1 and no exchange is running. `ss_n` then falls on the clock edge that takes the write. Otherwise no exchange starts and no completion flag appears. Clearing the enable bit aborts a running exchange on the next clock.
- R3: Each exchange produces exactly 16 `sck` edges. The byte written leaves on `mosi`, the byte on `miso` is captured, and data-register reads return it afterwards.
- R4: Control bit 5 = 1 sends and assembles least significant bit first; 0 means most significant bit first.
- R5: Control bit 3 sets the idle `sck` level, and `sck` returns to that level after the sixteenth edge.
- R6: Control bit 2 = 0: the first bit is on `mosi` before the first edge, `miso` is sampled on odd (leading) edges, and `mosi` changes on even edges. Bit 2 = 1: `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: Let D be 4, 16, 64 or 128 for rate select 0..3, halved when status bit 0 is 1, and let H = D/2. Edge k of an exchange comes kH clock cycles after the edge that takes the write.
- R8: Status bit 7 rises together with `ss_n`, 18H cycles after the edge that takes the write.
- R9: A data write during an exchange sets status bit 6 and leaves the byte being sent unchanged.
- R10: Status bits 7 and 6 clear on a data-register access only if a status read has happened while one of them was set. A data access without that read leaves them set.
- R11: `irq` equals status bit 7 AND control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle, used for flag clearing |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
A stray or missing tick in the prescaler moves an `sck` edge off its kH slot within one half period. A bad edge counter shows up as a wrong edge count, a wrong final `sck` level, or a completion time other than 18H. A shifter that takes the wrong phase or order garbles the byte seen by the bench's slave model, or the byte read back, by the end of the same exchange. Flag logic faults show at the status port on the next access, because every exchange ends with a read-and-clear sequence that is checked.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;

  localparam int PRE_W = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} xfer_state_e;

  // System clocks per sck half period.
  function automatic logic [PRE_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [PRE_W-1:0] base;
    case (rate)
      2'd0:    base = PRE_W'(2);
      2'd1:    base = PRE_W'(8);
      2'd2:    base = PRE_W'(32);
      default: base = PRE_W'(64);
    endcase
    return base >> dbl;
  endfunction

endpackage

// File: rtl/spi_mc_prescaler.sv
module spi_mc_prescaler #(
  parameter int HW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + HW'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(tick) && half != HW'(1)) |-> !tick); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half)); // R7

endmodule

// File: rtl/spi_mc_shifter.sv
module spi_mc_shifter
  import spi_mc_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          lsb_first,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [HW-1:0] half_in,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic [HW-1:0] half_l,
  output logic          sck,
  output logic          mosi,
  output logic          ss_n,
  output logic          done_pulse,
  output logic [DW-1:0] rx_byte
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  xfer_state_e   state;
  logic [EW-1:0] edge_cnt;
  logic          hold_cnt;
  logic          phase;
  logic [DW-1:0] tx_sr;
  logic [DW-1:0] rx_sr;
  logic          lsb_l, cpol_l, cpha_l;

  // Inserts one bit at the end the chosen order fills from.
  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] sr, input logic b,
                                             input logic lsb);
    return lsb ? {b, sr[DW-1:1]} : {sr[DW-2:0], b};
  endfunction

  logic leading, edge_ev, sample_ev, shift_ev, last_edge;

  assign leading    = ~edge_cnt[0];
  assign edge_ev    = (state == ST_SHIFT) && tick;
  assign sample_ev  = edge_ev && (cpha_l ? !leading : leading);
  assign shift_ev   = edge_ev && (cpha_l ? (leading && edge_cnt != '0) : !leading);
  assign last_edge  = (edge_cnt == EW'(EDGES - 1));
  assign done_pulse = enable && (state == ST_HOLD) && tick && hold_cnt;

  assign busy = (state != ST_IDLE);
  assign ss_n = ~busy;
  assign sck  = busy ? (cpol_l ^ phase) : cpol;
  assign mosi = lsb_l ? tx_sr[0] : tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      hold_cnt <= 1'b0;
      phase    <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
      lsb_l    <= 1'b0;
      cpol_l   <= 1'b0;
      cpha_l   <= 1'b0;
      half_l   <= HW'(1);
    end else if (!enable) begin
      state <= ST_IDLE;
      phase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_SHIFT;
          tx_sr    <= tx_byte;
          rx_sr    <= '0;
          edge_cnt <= '0;
          hold_cnt <= 1'b0;
          phase    <= 1'b0;
          lsb_l    <= lsb_first;
          cpol_l   <= cpol;
          cpha_l   <= cpha;
          half_l   <= half_in;
        end
        ST_SHIFT: if (tick) begin
          phase    <= ~phase;
          edge_cnt <= edge_cnt + EW'(1);
          if (sample_ev) rx_sr <= push_bit(rx_sr, miso, lsb_l);
          if (shift_ev)  tx_sr <= push_bit(tx_sr, 1'b0, lsb_l);
          if (last_edge) state <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          hold_cnt <= 1'b1;
          if (hold_cnt) begin
            state   <= ST_IDLE;
            rx_byte <= rx_sr;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sck)) |-> $past(tick)); // R7
  AST_SCK_HOME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ss_n) && $past(enable)) |-> ($past(sck) == $past(cpol_l))); // R5
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ss_n); // R2
  AST_MOSI_HELD_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> $stable(mosi)); // R6

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spi_mc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              dbl;
  logic              done_flag, collide_flag, armed;
  logic              busy, tick, done_pulse;
  logic [PRE_W-1:0]  half_l;
  logic [DATA_W-1:0] rx_byte;

  logic data_acc, data_wr, stat_rd, run_ok, start, coll_ev, flag_clr;

  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign data_wr  = reg_wr && (reg_addr == ADDR_DATA);
  assign stat_rd  = reg_rd && (reg_addr == ADDR_STAT);
  assign run_ok   = ctrl.enable && ctrl.master;
  assign start    = data_wr && run_ok && !busy;
  assign coll_ev  = data_wr && busy;
  assign flag_clr = data_acc && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl         <= '0;
      dbl          <= 1'b0;
      done_flag    <= 1'b0;
      collide_flag <= 1'b0;
      armed        <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[7:0]);
      if (reg_wr && reg_addr == ADDR_STAT) dbl  <= reg_wdata[0];

      if (done_pulse)    done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;

      if (coll_ev)       collide_flag <= 1'b1;
      else if (flag_clr) collide_flag <= 1'b0;

      if (flag_clr)                                    armed <= 1'b0;
      else if (stat_rd && (done_flag || collide_flag)) armed <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'(ctrl);
      ADDR_STAT: reg_rdata = DATA_W'({done_flag, collide_flag, 5'b0, dbl});
      ADDR_DATA: reg_rdata = rx_byte;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = done_flag & ctrl.irq_en;

  spi_mc_prescaler #(.HW(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .half (half_l),
    .tick (tick)
  );

  spi_mc_shifter #(.DW(DATA_W), .HW(PRE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (run_ok),
    .start     (start),
    .tx_byte   (reg_wdata),
    .lsb_first (ctrl.lsb_first),
    .cpol      (ctrl.cpol),
    .cpha      (ctrl.cpha),
    .half_in   (half_period(ctrl.rate, dbl)),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .half_l    (half_l),
    .sck       (sck),
    .mosi      (mosi),
    .ss_n      (ss_n),
    .done_pulse(done_pulse),
    .rx_byte   (rx_byte)
  );

  AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $rose(ss_n)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.irq_en |-> !irq); // R11
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(armed)); // R10

endmodule

// File: tb/spi_master_ctrl_tb.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck, mosi, ss_n, irq;
  logic       miso = 1'b0;

  int cyc = 0;
  int t_edge = 0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_master_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 t_edge = cyc;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_strobe(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int half_of(input int rate, input int dbl);
    int d = (rate == 3) ? 128 : (4 << (2 * rate));
    return (d / 2) >> dbl;
  endfunction

  function automatic int bpos(input bit lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  task automatic run_xfer(input bit lsb, input bit cpol, input bit cpha, input int rate,
                          input bit dbl, input bit ien, input logic [7:0] m_byte,
                          input logic [7:0] s_byte, input bit coll, input logic [7:0] c_byte);
    int h = half_of(rate, dbl);
    int t0;
    logic [7:0] got = '0;
    logic [7:0] d;
    wr(2'd0, {ien, 1'b1, lsb, 1'b1, cpol, cpha, rate[1:0]});
    wr(2'd1, {7'b0, dbl});
    @(negedge clk);
    chk(sck == cpol, "R5 idle sck", int'(sck), int'(cpol));
    if (!cpha) miso = s_byte[bpos(lsb, 0)];
    wr(2'd2, m_byte);
    t0 = t_edge;
    chk(ss_n == 1'b0, "R2 select low", int'(ss_n), 0);
    for (int k = 1; k <= 16; k++) begin
      int i = (k - 1) / 2;
      bit lead = (k % 2) == 1;
      @(sck);
      #1;
      chk(cyc - t0 == k * h, "R7 edge time", cyc - t0, k * h);
      if (lead == !cpha) got[bpos(lsb, i)] = mosi;
      else if (!cpha) begin
        if (k < 16) miso = s_byte[bpos(lsb, i + 1)];
      end else miso = s_byte[bpos(lsb, i)];
      if (coll && k == 4) begin
        wr(2'd2, c_byte);
        peek(2'd1, d);
        chk(d[6] == 1'b1, "R9 collision flag", int'(d[6]), 1);
      end
    end
    chk(sck == cpol, "R5 sck home after 16 edges", int'(sck), int'(cpol));
    @(posedge ss_n);
    #1;
    chk(cyc - t0 == 18 * h, "R8 completion time", cyc - t0, 18 * h);
    chk(got == m_byte, lsb ? "R4 R3 byte at slave" : "R3 byte at slave", got, m_byte);
    peek(2'd1, d);
    chk(d[7] == 1'b1, "R8 completion flag", int'(d[7]), 1);
    chk(irq == ien, "R11 irq", int'(irq), int'(ien));
    rd_strobe(2'd1, d);
    rd_strobe(2'd2, d);
    chk(d == s_byte, cpha ? "R6 R3 byte from slave" : "R3 byte from slave", d, s_byte);
    peek(2'd1, d);
    chk(d[7:6] == 2'b00, "R10 flags cleared", d[7:6], 0);
    chk(irq == 1'b0, "R11 irq cleared", int'(irq), 0);
  endtask

  task automatic no_start(input logic [7:0] ctrl_val, input string tag);
    logic [7:0] d;
    bit stayed = 1'b1;
    wr(2'd0, ctrl_val);
    wr(2'd2, 8'h66);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (!ss_n) stayed = 1'b0;
    end
    chk(stayed, tag, int'(stayed), 1);
    peek(2'd1, d);
    chk(d[7] == 1'b0, tag, int'(d[7]), 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ss_n == 1'b1 && sck == 1'b0 && irq == 1'b0, "R1 reset pins",
        {ss_n, sck, irq}, 3'b100);
    peek(2'd0, d);
    chk(d == 8'h00, "R1 reset control", d, 0);
    peek(2'd1, d);
    chk(d == 8'h00, "R1 reset status", d, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 64; v++) begin
      logic [5:0] b = 6'(v);
      run_xfer(b[0], b[1], b[2], int'(b[4:3]), b[5], b[0] ^ b[3],
               8'h5A ^ 8'(v * 29), 8'hC3 + 8'(v * 13), 1'b0, 8'h00);
    end

    // R9: collision during a frame at H = 4
    run_xfer(1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b1, 8'h93, 8'h2E, 1'b1, 8'h0F);

    // R10: data access without prior status read keeps the flag
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'hE1);
    @(posedge ss_n);
    rd_strobe(2'd2, d);
    peek(2'd1, d);
    chk(d[7] == 1'b1, "R10 flag kept without status read", int'(d[7]), 1);
    rd_strobe(2'd1, d);
    rd_strobe(2'd2, d);
    peek(2'd1, d);
    chk(d[7] == 1'b0, "R10 flag cleared after sequence", int'(d[7]), 0);

    no_start(8'h90, "R2 disabled block does not start");
    no_start(8'hC0, "R2 non-master does not start");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule